// File: doc/BRIEF.md
# Trigger Rate Limiter With Front-End Buffer Emulation

This block sits in the 40 MHz bunch-crossing clock domain, one cycle of 25 ns per step. Each cycle it receives one hardware trigger decision and passes it on to the readout electronics. Before it forwards an accept, it checks a cycle-accurate model of a remote front-end derandomizing buffer. That buffer holds a bounded number of events. It empties at a fixed rate of one event per drain period, and the block cannot see it directly.

When forwarding an accept would overfill that buffer, the block turns the accept into a reject. It also turns accepts into rejects while the downstream readout units hold the asynchronous throttle input high. That input is resynchronized before use.

Two wide counters record how many accepts were forwarded and how many were vetoed. A synchronous clear input zeroes both counters.

Top module: `trig_rate_limiter`

## Requirements
- R1: After reset, accept_out is 0, both counters are 0 and the emulated buffer is empty, so DEPTH (16) back-to-back accepts are all forwarded.
- R2: A trigger accept (trig_in high) that is allowed appears as accept_out high exactly one clock cycle later; accept_out is never high without a trigger accept on the previous cycle.
- R3: The emulated buffer holds at most DEPTH (16) events. An accept that arrives while the buffer holds DEPTH events, in a cycle where no event finishes draining, is forwarded as a reject (accept_out stays low).
- R4: throttle_async passes through two flip-flops before use. An accept arriving in the cycle after the second of two rising edges at which throttle_async was sampled high is vetoed. One arriving in the cycle after the first such edge is still judged on buffer room only.
- R5: Draining runs back to back at one event per DRAIN (36) cycles. An accept into an empty buffer forwarded at cycle t finishes draining at cycle t+36, and its slot is free for an accept in that same cycle.
- R6: When an accept arrives in the cycle an event finishes draining, the accept is forwarded even if the buffer holds DEPTH events, and the occupancy stays the same.
- R7: accept_count increases by one for each forwarded accept. veto_count increases by one for each trigger accept that is vetoed for lack of room or by throttle. A cycle with trig_in low changes neither counter.
- R8: cnt_clear high for a cycle zeroes both counters at the next edge, discarding any increment from that cycle. It does not change the emulated buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Hardware trigger decision for this cycle (1 = accept) |
| throttle_async | input | 1 | Asynchronous throttle from the readout units |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| accept_out | output | 1 | Registered forwarded accept |
| accept_count | output | 32 | Number of forwarded accepts |
| veto_count | output | 32 | Number of vetoed accepts |

## Verification
The bench builds the block with its default values, a 16-event buffer and a 36-cycle drain period. At these values a dense burst fills the buffer in 16 cycles, and an idle stretch of about 600 cycles empties it. So random phases with high trigger density reach the full state, the simultaneous drain-and-accept case and throttle-plus-full overlaps many times within a few thousand cycles. A directed sequence from an empty buffer pins the exact count of 17 forwarded and 20 vetoed out of 37 consecutive accepts.

// File: rtl/trl_pkg.sv
package trl_pkg;

  // Room exists when the buffer is below capacity or a slot frees this cycle.
  function automatic logic has_room(input int occ, input int depth, input logic drain_done);
    return (occ < depth) || drain_done;
  endfunction

  // Next occupancy from one grant and one drain completion.
  function automatic int occ_step(input int occ, input logic grant, input logic drain_done);
    return occ + (grant ? 1 : 0) - (drain_done ? 1 : 0);
  endfunction

endpackage

// File: rtl/trl_sync.sv
module trl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/trl_buffer_model.sv
module trl_buffer_model #(
  parameter int DEPTH = 16,
  parameter int DRAIN = 36,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int TMR_W = $clog2(DRAIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             block,
  output logic             grant,
  output logic             drain_done,
  output logic [OCC_W-1:0] occ
);
  logic [TMR_W-1:0] tmr_q;
  logic [OCC_W-1:0] occ_q;

  assign drain_done = (occ_q != '0) && (tmr_q == TMR_W'(DRAIN - 1));
  assign grant      = trig && !block && trl_pkg::has_room(int'(occ_q), DEPTH, drain_done);
  assign occ        = occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      tmr_q <= '0;
    end else begin
      occ_q <= OCC_W'(trl_pkg::occ_step(int'(occ_q), grant, drain_done));
      if (occ_q == '0 || drain_done) tmr_q <= '0;
      else                           tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/trl_event_counter.sv
module trl_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/trig_rate_limiter.sv
module trig_rate_limiter #(
  parameter int DEPTH = 16,
  parameter int DRAIN = 36,
  parameter int CNT_W = 32,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             throttle_async,
  input  logic             cnt_clear,
  output logic             accept_out,
  output logic [CNT_W-1:0] accept_count,
  output logic [CNT_W-1:0] veto_count
);
  logic             thr_s;
  logic             allow;
  logic             veto;
  logic             drain_done;
  logic [OCC_W-1:0] occ;

  trl_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(throttle_async), .q_sync(thr_s)
  );

  trl_buffer_model #(.DEPTH(DEPTH), .DRAIN(DRAIN)) u_buf (
    .clk(clk), .rst_n(rst_n), .trig(trig_in), .block(thr_s),
    .grant(allow), .drain_done(drain_done), .occ(occ)
  );

  assign veto = trig_in && !allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept_out <= 1'b0;
    else        accept_out <= allow;
  end

  trl_event_counter #(.W(CNT_W)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(allow), .count(accept_count)
  );

  trl_event_counter #(.W(CNT_W)) u_veto_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(veto), .count(veto_count)
  );
endmodule

// File: rtl/trl_checker.sv
module trl_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_in,
  input logic             cnt_clear,
  input logic             accept_out,
  input logic [CNT_W-1:0] accept_count,
  input logic [CNT_W-1:0] veto_count,
  input logic             thr_s,
  input logic             allow,
  input logic             drain_done,
  input logic [OCC_W-1:0] occ
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  a_r2_accept_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    accept_out |-> $past(trig_in));

  a_r4_throttle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    thr_s |=> !accept_out);

  a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done && allow) |=> (occ == $past(occ)));

  a_r5_drop_only_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < $past(occ)) |-> $past(drain_done));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (accept_count == '0 && veto_count == '0));

  a_r7_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_in && !cnt_clear) |=> ($stable(accept_count) && $stable(veto_count)));
endmodule

bind trig_rate_limiter trl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cnt_clear(cnt_clear),
  .accept_out(accept_out), .accept_count(accept_count), .veto_count(veto_count),
  .thr_s(thr_s), .allow(allow), .drain_done(drain_done), .occ(occ)
);

// File: tb/trig_rate_limiter_test.sv
`timescale 1ns/1ps
module trig_rate_limiter_test;
  localparam int DEPTH = 16;
  localparam int DRAIN = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0;
  logic throttle_async = 1'b0;
  logic cnt_clear = 1'b0;
  logic accept_out;
  logic [31:0] accept_count, veto_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model state
  int  m_occ = 0, m_tmr = 0;
  bit  m_s1 = 0, m_s2 = 0;
  bit  e_out = 0;
  logic [31:0] e_acc = 0, e_veto = 0;
  string out_tag;

  always #5 clk = ~clk;

  trig_rate_limiter uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .throttle_async(throttle_async),
    .cnt_clear(cnt_clear), .accept_out(accept_out),
    .accept_count(accept_count), .veto_count(veto_count)
  );

  function automatic bit slot_free(int occ, int tmr);
    return (occ != 0) && (tmr == DRAIN - 1);
  endfunction

  function automatic bit may_pass(bit trig, bit thr, int occ, bit freed);
    return trig && !thr && (occ < DEPTH || freed);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, advance model, compare after the edge.
  task automatic step(bit trig, bit thr, bit clr);
    bit freed, pass;
    @(negedge clk);
    trig_in = trig; throttle_async = thr; cnt_clear = clr;
    freed = slot_free(m_occ, m_tmr);
    pass  = may_pass(trig, m_s2, m_occ, freed);
    if (trig && m_s2)                      out_tag = "R4";
    else if (trig && freed && m_occ == DEPTH) out_tag = "R6";
    else if (trig && m_occ == DEPTH)       out_tag = "R3";
    else if (trig && freed)                out_tag = "R5";
    else                                   out_tag = "R2";
    e_out = pass;
    if (clr) begin e_acc = 0; e_veto = 0; end
    else begin
      if (pass) e_acc++;
      if (trig && !pass) e_veto++;
    end
    if (m_occ == 0 || freed) m_tmr = 0; else m_tmr++;
    m_occ = m_occ + (pass ? 1 : 0) - (freed ? 1 : 0);
    m_s2 = m_s1; m_s1 = thr;
    @(posedge clk); #1;
    check(out_tag, {31'b0, accept_out}, {31'b0, e_out});
    check(clr ? "R8" : "R7 accepts", accept_count, e_acc);
    check(clr ? "R8" : "R7 vetoes", veto_count, e_veto);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #22;
    check("R1 accept_out", {31'b0, accept_out}, 32'd0);
    check("R1 accept_count", accept_count, 32'd0);
    check("R1 veto_count", veto_count, 32'd0);
    rst_n = 1'b1;

    // R1/R3/R5/R6: from empty, 37 consecutive accepts -> 17 pass, 20 vetoed
    step(0, 0, 1);
    for (int i = 0; i < 37; i++) step(1, 0, 0);
    check("R6 burst accepts", accept_count, 32'd17);
    check("R3 burst vetoes", veto_count, 32'd20);

    // R8: clear mid-traffic while buffer is full
    step(1, 0, 1);
    check("R8 cleared", accept_count, 32'd0);

    // R4: throttle latency, two edges before effect
    for (int i = 0; i < 700; i++) step(0, 0, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);

    // random phases of varying density and throttle activity
    for (int ph = 0; ph < 40; ph++) begin
      int dens = $urandom_range(100, 5);
      int thr_pct = (ph % 3 == 0) ? $urandom_range(40, 0) : 0;
      bit thr_lvl = 0;
      for (int c = 0; c < 400; c++) begin
        if ($urandom_range(99, 0) < 8) thr_lvl = ($urandom_range(99, 0) < thr_pct);
        step($urandom_range(99, 0) < dens, thr_lvl, $urandom_range(999, 0) == 0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule